// File: doc/BRIEF.md
# Branch Target Buffer Predictor with Static Fallback

This block predicts, for a near branch at the fetch address, whether it will be taken and where it goes. It keeps a direct-mapped, tagged table of recently seen branches; each slot stores a tag, the branch target, the branch kind and a 2-bit saturating direction counter. A lookup presents the fetch PC together with the target that pre-decode computed from the branch displacement. One cycle later the block reports whether the prediction came from the table, the predicted direction and the predicted target.

When the table has no matching slot, the block applies a fixed rule. A branch that jumps to a lower address (a loop back-edge) is predicted taken, and any other branch is predicted not taken. The table learns only from retired branches, so speculative fetch never disturbs its state. Far transfers are excluded from both lookup and training.

Top module: `btb_predictor`

## Requirements
- R1: While reset is low and in the first cycle after it, all prediction outputs are zero, and every slot is empty after reset, so any lookup then misses (pred_hit=0).
- R2: On a table miss, pred_hit=0 and pred_target equals the lookup's static target. pred_taken=1 exactly when that target is strictly lower than the lookup PC, so an equal or higher target gives 0.
- R3: Outputs are registered one cycle after the lookup. pred_valid=1 only in the cycle after lk_valid=1 with lk_far=0. Otherwise pred_valid, pred_hit, pred_taken and pred_target are all 0.
- R4: A taken retirement of a branch with no slot allocates one. A later lookup of that PC hits, predicts taken and returns the retired target, overriding the static rule. A taken retirement that hits replaces the stored target with the new one.
- R5: A not-taken retirement of a conditional branch (rt_kind=2'b00) that misses allocates nothing, and a later lookup still misses.
- R6: The counter of a conditional slot steps up on a taken retirement and down on a not-taken one, and saturates at 2'b11 and 2'b00. Values 2'b10 and 2'b11 predict taken, and 2'b00 and 2'b01 predict not taken. A new slot starts at 2'b10 if the branch was taken and at 2'b01 if it was not. A not-taken retirement that hits leaves the stored target unchanged.
- R7: Slots of kind call/jump/indirect (rt_kind=2'b01) or return (rt_kind=2'b10) always predict taken, whatever their counter. A not-taken retirement of such a kind that misses still allocates a slot.
- R8: Far transfers (rt_kind=2'b11 on retirement, lk_far=1 on lookup) never write the table, and a far lookup gives pred_valid=0.
- R9: A lookup and a retirement in the same cycle are both served, and the lookup sees the table as it was before that retirement.
- R10: Slot index is PC bits [IDX_W+1:2] and tag is the PC bits above them. A PC with the same index but a different tag misses, and a taken retirement of it replaces the old slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_far | input | 1 | Lookup is a far transfer (not predicted) |
| lk_pc | input | PC_W | Fetch PC of the branch |
| lk_static_tgt | input | PC_W | Target from the decoded displacement |
| rt_valid | input | 1 | A branch retires this cycle |
| rt_kind | input | 2 | 00 conditional, 01 call/jump/indirect, 10 return, 11 far |
| rt_taken | input | 1 | Resolved direction |
| rt_pc | input | PC_W | PC of the retired branch |
| rt_target | input | PC_W | Resolved target |
| pred_valid | output | 1 | Prediction present |
| pred_hit | output | 1 | Prediction came from the table |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | PC_W | Predicted target |

## Verification
The hardest states to reach are the saturation corners of the direction counter, because the only view of a counter is the predicted direction, and that shows only its top bit. The stimulus drives one conditional branch with runs of same-direction retirements past each end of the range. It then reverses direction and looks the branch up again at points where a counter that wrapped would predict the opposite way from one that saturated. Lookups issued in the same cycle as a retirement check that the old contents are returned. A second PC that maps to the same slot checks tag replacement.

// File: rtl/btb_pkg.sv
// Package btb_pkg: shared types and helpers for the branch target buffer.
// Assumes a 2-bit direction counter; branch kinds are encoded on 2 bits.
package btb_pkg;

    localparam int CTR_W = 2;

    typedef enum logic [1:0] {
        BK_COND   = 2'b00,
        BK_UNCOND = 2'b01,
        BK_RETURN = 2'b10,
        BK_FAR    = 2'b11
    } br_kind_e;

    localparam logic [CTR_W-1:0] CTR_NEW_TAKEN = 2'b10;
    localparam logic [CTR_W-1:0] CTR_NEW_NOT   = 2'b01;

    // One saturating step of the direction counter.
    function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] c,
                                                   input logic taken);
        logic [CTR_W-1:0] r;
        r = c;
        if (taken && c != {CTR_W{1'b1}}) r = c + 1'b1;
        if (!taken && c != {CTR_W{1'b0}}) r = c - 1'b1;
        return r;
    endfunction

    // Direction predicted by a stored slot.
    function automatic logic slot_taken(input br_kind_e k,
                                        input logic [CTR_W-1:0] c);
        return (k != BK_COND) || c[CTR_W-1];
    endfunction

endpackage

// File: rtl/btb_store.sv
// Module btb_store: slot storage with two combinational read ports
// (lookup and retirement) and one write port applied at the clock edge.
// Assumes reads return contents from before a write in the same cycle.
module btb_store
    import btb_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_vld,
    output logic [TAG_W-1:0] ra_tag,
    output logic [PC_W-1:0]  ra_tgt,
    output br_kind_e         ra_kind,
    output logic [CTR_W-1:0] ra_ctr,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_vld,
    output logic [TAG_W-1:0] rb_tag,
    output logic [PC_W-1:0]  rb_tgt,
    output logic [CTR_W-1:0] rb_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_tgt,
    input  br_kind_e         wr_kind,
    input  logic [CTR_W-1:0] wr_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    logic             s_vld  [DEPTH];
    logic [TAG_W-1:0] s_tag  [DEPTH];
    logic [PC_W-1:0]  s_tgt  [DEPTH];
    br_kind_e         s_kind [DEPTH];
    logic [CTR_W-1:0] s_ctr  [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        // Per-slot register: clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_vld[e]  <= 1'b0;
                s_tag[e]  <= '0;
                s_tgt[e]  <= '0;
                s_kind[e] <= BK_COND;
                s_ctr[e]  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                s_vld[e]  <= 1'b1;
                s_tag[e]  <= wr_tag;
                s_tgt[e]  <= wr_tgt;
                s_kind[e] <= wr_kind;
                s_ctr[e]  <= wr_ctr;
            end
        end
    end

    // Lookup read port.
    always_comb begin
        ra_vld  = s_vld[ra_idx];
        ra_tag  = s_tag[ra_idx];
        ra_tgt  = s_tgt[ra_idx];
        ra_kind = s_kind[ra_idx];
        ra_ctr  = s_ctr[ra_idx];
    end

    // Retirement read port (kind is rewritten on every update, so not read).
    always_comb begin
        rb_vld = s_vld[rb_idx];
        rb_tag = s_tag[rb_idx];
        rb_tgt = s_tgt[rb_idx];
        rb_ctr = s_ctr[rb_idx];
    end

endmodule

// File: rtl/btb_lookup.sv
// Module btb_lookup: turns a lookup and the addressed slot into a registered
// prediction, using the backward-taken rule when the slot does not match.
// Assumes the slot fields arrive combinationally for lk_pc's index.
module btb_lookup
    import btb_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26,
    parameter int PC_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_far,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic [PC_W-1:0]  lk_static_tgt,
    input  logic             sl_vld,
    input  logic [TAG_W-1:0] sl_tag,
    input  logic [PC_W-1:0]  sl_tgt,
    input  br_kind_e         sl_kind,
    input  logic [CTR_W-1:0] sl_ctr,
    output logic             pred_valid,
    output logic             pred_hit,
    output logic             pred_taken,
    output logic [PC_W-1:0]  pred_target
);
    logic            go;
    logic            hit;
    logic            nx_taken;
    logic [PC_W-1:0] nx_target;

    // Decide hit and next prediction from slot or static rule.
    always_comb begin
        go  = lk_valid && !lk_far;
        hit = sl_vld && (sl_tag == lk_pc[PC_W-1 -: TAG_W]);
        if (hit) begin
            nx_taken  = slot_taken(sl_kind, sl_ctr);
            nx_target = sl_tgt;
        end else begin
            nx_taken  = lk_static_tgt < lk_pc;
            nx_target = lk_static_tgt;
        end
    end

    // Register the prediction; zero when no lookup was served.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            pred_valid  <= 1'b0;
            pred_hit    <= 1'b0;
            pred_taken  <= 1'b0;
            pred_target <= '0;
        end else begin
            pred_valid  <= 1'b1;
            pred_hit    <= hit;
            pred_taken  <= nx_taken;
            pred_target <= nx_target;
        end
    end

endmodule

// File: rtl/btb_train.sv
// Module btb_train: computes the slot write for a retired branch.
// Assumes the addressed slot is read combinationally; far transfers and
// not-taken conditional misses produce no write.
module btb_train
    import btb_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26,
    parameter int PC_W   = 32,
    parameter int ALIGN_W = 2
) (
    input  logic             rt_valid,
    input  br_kind_e         rt_kind,
    input  logic             rt_taken,
    input  logic [PC_W-1:0]  rt_pc,
    input  logic [PC_W-1:0]  rt_target,
    input  logic             sl_vld,
    input  logic [TAG_W-1:0] sl_tag,
    input  logic [PC_W-1:0]  sl_tgt,
    input  logic [CTR_W-1:0] sl_ctr,
    output logic [IDX_W-1:0] rd_idx,
    output logic             rt_hit,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [TAG_W-1:0] wr_tag,
    output logic [PC_W-1:0]  wr_tgt,
    output br_kind_e         wr_kind,
    output logic [CTR_W-1:0] wr_ctr
);
    logic [TAG_W-1:0] rt_tag;

    // Split the retired PC into slot index and tag.
    always_comb begin
        rd_idx = rt_pc[ALIGN_W +: IDX_W];
        rt_tag = rt_pc[PC_W-1 -: TAG_W];
        rt_hit = sl_vld && (sl_tag == rt_tag);
    end

    // Choose between update-in-place, allocation, or no write.
    always_comb begin
        wr_idx  = rd_idx;
        wr_tag  = rt_tag;
        wr_kind = rt_kind;
        wr_en   = 1'b0;
        wr_tgt  = rt_target;
        wr_ctr  = rt_taken ? CTR_NEW_TAKEN : CTR_NEW_NOT;
        if (rt_valid && rt_kind != BK_FAR) begin
            if (rt_hit) begin
                wr_en  = 1'b1;
                wr_ctr = ctr_step(sl_ctr, rt_taken);
                wr_tgt = rt_taken ? rt_target : sl_tgt;
            end else if (rt_taken || rt_kind != BK_COND) begin
                wr_en  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/btb_predictor.sv
// Module btb_predictor: direct-mapped, tagged branch target buffer with a
// backward-taken static fallback. Training comes only from retirement.
// Assumes PCs are aligned to 2**ALIGN_W bytes.
module btb_predictor
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int ALIGN_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic            lk_far,
    input  logic [PC_W-1:0] lk_pc,
    input  logic [PC_W-1:0] lk_static_tgt,
    input  logic            rt_valid,
    input  logic [1:0]      rt_kind,
    input  logic            rt_taken,
    input  logic [PC_W-1:0] rt_pc,
    input  logic [PC_W-1:0] rt_target,
    output logic            pred_valid,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target
);
    localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

    logic             ra_vld, rb_vld;
    logic [TAG_W-1:0] ra_tag, rb_tag;
    logic [PC_W-1:0]  ra_tgt, rb_tgt;
    br_kind_e         ra_kind;
    logic [CTR_W-1:0] ra_ctr, rb_ctr;
    logic [IDX_W-1:0] rb_idx;
    logic             rt_hit;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    logic [PC_W-1:0]  wr_tgt;
    br_kind_e         wr_kind;
    logic [CTR_W-1:0] wr_ctr;
    br_kind_e         rt_kind_e;
    logic             unused_align;

    // Type the retire kind and mark alignment bits as intentionally unused.
    always_comb begin
        rt_kind_e    = br_kind_e'(rt_kind);
        unused_align = ^{rt_pc[ALIGN_W-1:0], lk_pc[ALIGN_W-1:0]};
    end

    btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(lk_pc[ALIGN_W +: IDX_W]),
        .ra_vld(ra_vld), .ra_tag(ra_tag), .ra_tgt(ra_tgt),
        .ra_kind(ra_kind), .ra_ctr(ra_ctr),
        .rb_idx(rb_idx),
        .rb_vld(rb_vld), .rb_tag(rb_tag), .rb_tgt(rb_tgt), .rb_ctr(rb_ctr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_tgt(wr_tgt), .wr_kind(wr_kind), .wr_ctr(wr_ctr)
    );

    btb_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_lookup (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_far(lk_far),
        .lk_pc(lk_pc), .lk_static_tgt(lk_static_tgt),
        .sl_vld(ra_vld), .sl_tag(ra_tag), .sl_tgt(ra_tgt),
        .sl_kind(ra_kind), .sl_ctr(ra_ctr),
        .pred_valid(pred_valid), .pred_hit(pred_hit),
        .pred_taken(pred_taken), .pred_target(pred_target)
    );

    btb_train #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W),
                .ALIGN_W(ALIGN_W)) u_train (
        .rt_valid(rt_valid), .rt_kind(rt_kind_e), .rt_taken(rt_taken),
        .rt_pc(rt_pc), .rt_target(rt_target),
        .sl_vld(rb_vld), .sl_tag(rb_tag), .sl_tgt(rb_tgt), .sl_ctr(rb_ctr),
        .rd_idx(rb_idx), .rt_hit(rt_hit),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_tgt(wr_tgt), .wr_kind(wr_kind), .wr_ctr(wr_ctr)
    );

endmodule

// File: rtl/btb_predictor_chk.sv
// Module btb_predictor_chk: temporal checks on the predictor, bound to the top.
// Assumes synchronous active-low reset.
module btb_predictor_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic            lk_far,
    input logic [PC_W-1:0] lk_pc,
    input logic [PC_W-1:0] lk_static_tgt,
    input logic            rt_valid,
    input logic [1:0]      rt_kind,
    input logic            rt_taken,
    input logic            rt_hit,
    input logic            wr_en,
    input logic            pred_valid,
    input logic            pred_hit,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_target
);
    // R3: a served lookup yields a prediction next cycle.
    p_served_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_far) |=> pred_valid);

    // R3 / R8: no lookup or a far lookup gives all-zero outputs.
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && !lk_far) |=>
            (!pred_valid && !pred_hit && !pred_taken && pred_target == '0));

    // R2: a miss follows the backward-taken rule with the static target.
    p_static_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_far) |=> (pred_hit ||
            (pred_taken == ($past(lk_static_tgt) < $past(lk_pc)) &&
             pred_target == $past(lk_static_tgt))));

    // R8: far retirements never write.
    p_far_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_kind == 2'b11) |-> !wr_en);

    // R5: not-taken conditional misses never allocate.
    p_nt_no_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_kind == 2'b00 && !rt_taken && !rt_hit) |-> !wr_en);

    // R4: every non-far retirement that is taken produces a write.
    p_taken_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_kind != 2'b11 && rt_taken) |-> wr_en);

endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_far(lk_far),
    .lk_pc(lk_pc), .lk_static_tgt(lk_static_tgt),
    .rt_valid(rt_valid), .rt_kind(rt_kind), .rt_taken(rt_taken),
    .rt_hit(rt_hit), .wr_en(wr_en),
    .pred_valid(pred_valid), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .pred_target(pred_target)
);

// File: tb/btb_predictor_test.sv
// Bench btb_predictor_test: vector table walk plus directed reset test.
module btb_predictor_test;

    localparam int PC_W = 32;

    typedef struct packed {
        logic        lv;
        logic        lf;
        logic [31:0] lpc;
        logic [31:0] ltgt;
        logic        rv;
        logic [1:0]  rk;
        logic        rtk;
        logic [31:0] rpc;
        logic [31:0] rtgt;
        logic        ev;
        logic        eh;
        logic        et;
        logic [31:0] etgt;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 37;
    // Rows: lookup(lv,lf,pc,tgt) retire(rv,kind,taken,pc,tgt) expect(v,hit,taken,tgt) req
    localparam vec_t VEC [NV] = '{
        '{1,0,32'h1000,32'h0F00, 0,2'b00,0,32'h0,32'h0,      1,0,1,32'h0F00, 2}, // R2 backward
        '{1,0,32'h2004,32'h2100, 0,2'b00,0,32'h0,32'h0,      1,0,0,32'h2100, 2}, // R2 forward
        '{1,0,32'h2004,32'h2004, 0,2'b00,0,32'h0,32'h0,      1,0,0,32'h2004, 2}, // R2 equal
        '{0,0,32'h0,32'h0,       1,2'b00,0,32'h1000,32'h1200, 0,0,0,32'h0,   3}, // R3 idle
        '{1,0,32'h1000,32'h1200, 0,2'b00,0,32'h0,32'h0,      1,0,0,32'h1200, 5}, // R5 no alloc
        '{1,0,32'h1000,32'h1200, 1,2'b00,1,32'h1000,32'h1200, 1,0,0,32'h1200, 9}, // R9 old view
        '{1,0,32'h1000,32'h0F00, 0,2'b00,0,32'h0,32'h0,      1,1,1,32'h1200, 4}, // R4 hit
        '{0,0,32'h0,32'h0,       1,2'b00,0,32'h1000,32'h5555, 0,0,0,32'h0,   6}, // 10->01
        '{1,0,32'h1000,32'h0F00, 0,2'b00,0,32'h0,32'h0,      1,1,0,32'h1200, 6}, // R6 01 nt
        '{0,0,32'h0,32'h0,       1,2'b00,0,32'h1000,32'h5555, 0,0,0,32'h0,   6}, // ->00
        '{0,0,32'h0,32'h0,       1,2'b00,0,32'h1000,32'h5555, 0,0,0,32'h0,   6}, // sat 00
        '{1,0,32'h1000,32'h0F00, 1,2'b00,1,32'h1000,32'h1200, 1,1,0,32'h1200, 9}, // R9 ->01
        '{1,0,32'h1000,32'h0F00, 0,2'b00,0,32'h0,32'h0,      1,1,0,32'h1200, 6}, // R6 01
        '{0,0,32'h0,32'h0,       1,2'b00,1,32'h1000,32'h1200, 0,0,0,32'h0,   6}, // ->10
        '{1,0,32'h1000,32'h1200, 0,2'b00,0,32'h0,32'h0,      1,1,1,32'h1200, 6}, // R6 10
        '{0,0,32'h0,32'h0,       1,2'b00,1,32'h1000,32'h1200, 0,0,0,32'h0,   6}, // ->11
        '{0,0,32'h0,32'h0,       1,2'b00,1,32'h1000,32'h1200, 0,0,0,32'h0,   6}, // sat 11
        '{0,0,32'h0,32'h0,       1,2'b00,0,32'h1000,32'h1200, 0,0,0,32'h0,   6}, // ->10
        '{1,0,32'h1000,32'h1200, 0,2'b00,0,32'h0,32'h0,      1,1,1,32'h1200, 6}, // R6 10
        '{0,0,32'h0,32'h0,       1,2'b00,0,32'h1000,32'h1200, 0,0,0,32'h0,   6}, // ->01
        '{1,0,32'h1000,32'h0F00, 0,2'b00,0,32'h0,32'h0,      1,1,0,32'h1200, 6}, // R6 01
        '{0,0,32'h0,32'h0,       1,2'b01,1,32'h2004,32'h8000, 0,0,0,32'h0,   7}, // alloc uncond
        '{0,0,32'h0,32'h0,       1,2'b01,0,32'h2004,32'h9999, 0,0,0,32'h0,   7}, // ctr ->01
        '{1,0,32'h2004,32'h2100, 0,2'b00,0,32'h0,32'h0,      1,1,1,32'h8000, 7}, // R7 always taken
        '{0,0,32'h0,32'h0,       1,2'b10,0,32'h3008,32'h9000, 0,0,0,32'h0,   7}, // return nt alloc
        '{1,0,32'h3008,32'h3100, 0,2'b00,0,32'h0,32'h0,      1,1,1,32'h9000, 7}, // R7 return
        '{0,0,32'h0,32'h0,       1,2'b11,1,32'h400C,32'hA000, 0,0,0,32'h0,   8}, // far retire
        '{1,0,32'h400C,32'h5000, 0,2'b00,0,32'h0,32'h0,      1,0,0,32'h5000, 8}, // R8 no alloc
        '{1,1,32'h400C,32'h3000, 0,2'b00,0,32'h0,32'h0,      0,0,0,32'h0,    8}, // R8 far lookup
        '{0,0,32'h0,32'h0,       1,2'b11,1,32'h1000,32'hB000, 0,0,0,32'h0,   8}, // far on existing
        '{1,0,32'h1000,32'h0F00, 0,2'b00,0,32'h0,32'h0,      1,1,0,32'h1200, 8}, // R8 unchanged
        '{1,0,32'h1040,32'h1000, 0,2'b00,0,32'h0,32'h0,      1,0,1,32'h1000, 10}, // R10 alias miss
        '{0,0,32'h0,32'h0,       1,2'b00,1,32'h1040,32'h7000, 0,0,0,32'h0,   10}, // replace
        '{1,0,32'h1000,32'h1200, 0,2'b00,0,32'h0,32'h0,      1,0,0,32'h1200, 10}, // R10 evicted
        '{1,0,32'h1040,32'h1000, 0,2'b00,0,32'h0,32'h0,      1,1,1,32'h7000, 10}, // R10 new owner
        '{0,0,32'h0,32'h0,       1,2'b00,1,32'h1040,32'h7100, 0,0,0,32'h0,   4}, // retarget
        '{1,0,32'h1040,32'h1000, 0,2'b00,0,32'h0,32'h0,      1,1,1,32'h7100, 4}  // R4 new target
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lk_valid = 1'b0, lk_far = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, lk_static_tgt = '0;
    logic            rt_valid = 1'b0, rt_taken = 1'b0;
    logic [1:0]      rt_kind = 2'b00;
    logic [PC_W-1:0] rt_pc = '0, rt_target = '0;
    logic            pred_valid, pred_hit, pred_taken;
    logic [PC_W-1:0] pred_target;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    btb_predictor #(.PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_far(lk_far),
        .lk_pc(lk_pc), .lk_static_tgt(lk_static_tgt),
        .rt_valid(rt_valid), .rt_kind(rt_kind), .rt_taken(rt_taken),
        .rt_pc(rt_pc), .rt_target(rt_target),
        .pred_valid(pred_valid), .pred_hit(pred_hit),
        .pred_taken(pred_taken), .pred_target(pred_target)
    );

    task automatic check(input string tag, input logic ev, input logic eh,
                         input logic et, input logic [31:0] etgt);
        checks++;
        if (pred_valid !== ev || pred_hit !== eh || pred_taken !== et ||
            pred_target !== etgt) begin
            failures++;
            $display("FAIL %s: got v=%b h=%b t=%b tgt=%h, expected v=%b h=%b t=%b tgt=%h",
                     tag, pred_valid, pred_hit, pred_taken, pred_target,
                     ev, eh, et, etgt);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_far = 0; lk_pc = '0; lk_static_tgt = '0;
        rt_valid = 0; rt_kind = 2'b00; rt_taken = 0; rt_pc = '0; rt_target = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a lookup held during reset
        repeat (3) @(negedge clk);
        lk_valid = 1; lk_pc = 32'h1000; lk_static_tgt = 32'h0F00;
        @(negedge clk);
        check("R1 during reset", 0, 0, 0, 32'h0);
        idle_inputs();
        rst_n = 1;
        @(negedge clk);
        check("R1 after reset", 0, 0, 0, 32'h0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            lk_valid = VEC[i].lv;   lk_far = VEC[i].lf;
            lk_pc = VEC[i].lpc;     lk_static_tgt = VEC[i].ltgt;
            rt_valid = VEC[i].rv;   rt_kind = VEC[i].rk;
            rt_taken = VEC[i].rtk;  rt_pc = VEC[i].rpc; rt_target = VEC[i].rtgt;
            @(posedge clk);
            #1;
            check($sformatf("R%0d row %0d", VEC[i].req, i),
                  VEC[i].ev, VEC[i].eh, VEC[i].et, VEC[i].etgt);
        end

        // R1: reset clears learned slots (0x1040 was learned taken above)
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        lk_valid = 1; lk_pc = 32'h1040; lk_static_tgt = 32'h2000;
        @(posedge clk);
        #1;
        check("R1 slots cleared", 1, 0, 0, 32'h2000);

        // R3: lookup held for consecutive cycles gives back-to-back results
        @(negedge clk);
        lk_pc = 32'h2004; lk_static_tgt = 32'h2100;
        @(posedge clk);
        #1;
        check("R3 back-to-back", 1, 1 == 0, 0, 32'h2100);
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #1;
        check("R3 drop", 0, 0, 0, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule